// File: doc/BRIEF.md
# Two-Wire Bus Register-Access Slave

This block lets a host controller on a two-wire serial bus (I2C) reach a 128-entry, byte-wide register space inside a chip. Both bus lines pass through a synchronizer and a majority-free glitch filter, which requires a level to hold for a number of consecutive cycles. The filtered lines are then watched for START, repeated START and STOP conditions. The block answers to the 7-bit device address `110100s`, where `s` is the level of a strap input. It acknowledges every byte it takes and, when it sends data, drives SDA only as an active-low output enable.

After the device address with a write direction, the host sends a sub-address byte. Its seven low bits pick a register, and its top bit chooses whether the register pointer steps by one after each data byte. Further bytes in the same write are passed out as one-cycle write strobes. To read, the host writes the sub-address, issues a repeated START and sends the device address with the read direction. The block then fetches each byte through a one-cycle read request and shifts it out MSB first, until the host answers a byte with a NACK.

Top module: `i2c_regport_slave`

## Requirements
- R1: A pulse on SCL or SDA shorter than FILT_LEN clock cycles (default 3) does not change the filtered bus level, so a one-cycle SDA spike during SCL high neither ends nor restarts a transfer.
- R2: SDA falling while SCL is high (START) begins a new address phase from any state, including in the middle of a write (repeated START), and keeps the register pointer.
- R3: The first byte after a START is matched on bits [7:1] against {6'b110100, addr_strap}, and bit 0 gives the direction (1 = read, 0 = write). On a mismatch the byte is not acknowledged, and SDA stays released until the next START.
- R4: Once addressed, the block acknowledges every byte it receives by asserting sda_oe from the SCL fall after the byte's eighth bit until the SCL fall after the ninth bit.
- R5: The byte after an address with the write direction is the sub-address: bits [6:0] load the register pointer, and bit 7 set means auto-increment.
- R6: Every data byte after the sub-address produces exactly one cycle of reg_wr, with reg_addr equal to the pointer and reg_wdata equal to the received byte.
- R7: With auto-increment set, the pointer advances by one, modulo 128, after each data byte written or read. With it clear, the pointer stays fixed.
- R8: After an address with the read direction, each byte is fetched with a one-cycle reg_rd on the rising SCL of the acknowledge clock that comes before it. reg_rdata is sampled one cycle later and driven MSB first, with sda_oe = 1 meaning a 0 bit.
- R9: A master NACK (SDA high on the acknowledge clock) after a read byte ends the read: no further reg_rd, and sda_oe stays low until the next START.
- R10: SDA rising while SCL is high (STOP) returns the block to idle. Bytes clocked afterwards without a START are neither acknowledged nor written.
- R11: While reset is held and just after it, sda_oe, reg_wr and reg_rd are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL by well over the filter latency |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Sets the least significant bit of the device address |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read request |
| reg_addr | output | 7 | Register pointer used with reg_wr and reg_rd |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Read data, sampled the cycle after reg_rd |

## Verification
A corrupted bit counter or phase register shows up within one byte time: an acknowledge lands on the wrong clock, a read bit is shifted, or a write strobe carries the sub-address as data. A wrong register pointer is seen at the next reg_wr or reg_rd as a wrong reg_addr, and as a wrong byte when the burst is read back. A state that fails to drop to idle after a mismatch, a NACK or a STOP shows at once as sda_oe pulling the line during bytes that must go unanswered.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  localparam int DATA_W = 8;
  localparam int REG_AW = 7;
  localparam logic [5:0] DEV_ADDR_HI = 6'b110100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_RDATA
  } phase_t;

  // Device address with the strapped least significant bit.
  function automatic logic [REG_AW-1:0] dev_addr(input logic strap);
    return {DEV_ADDR_HI, strap};
  endfunction

  // Register pointer after a data byte; wraps inside the register space.
  function automatic logic [REG_AW-1:0] ptr_next(input logic [REG_AW-1:0] p,
                                                 input logic inc);
    return p + {{(REG_AW-1){1'b0}}, inc};
  endfunction
endpackage

// File: rtl/i2c_rp_filt.sv
module i2c_rp_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      lvl_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)       lvl_q <= 1'b1;
      else if (~|win_q) lvl_q <= 1'b0;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/i2c_rp_cond.sv
module i2c_rp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2c_rp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  output logic              sda_oe,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] BIT_ACK  = CNT_W'(DATA_W);

  // Line conditioning: index 1 = SCL, index 0 = SDA.
  logic [1:0] pin_raw, pin_flt;
  assign pin_raw = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_rp_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_i(pin_raw[g]),
      .lvl_o(pin_flt[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = pin_flt[1];
  assign sda_f = pin_flt[0];

  logic scl_rise, scl_fall, start_ev, stop_ev;
  i2c_rp_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  phase_t            st;
  logic [CNT_W-1:0]  bitcnt;
  logic              got_rise;
  logic [DATA_W-1:0] rx_sr, tx_sr;
  logic              ack_drv, rw_q, inc_q, rd_cap;
  logic [REG_AW-1:0] ptr_q;

  // Named internal events.
  logic rx_phase, bit_fall, byte_done, ack_rise;
  logic addr_hit, addr_done, wr_fire, rd_req, mst_nack;

  assign rx_phase  = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_WDATA);
  assign bit_fall  = scl_fall && got_rise && (st != ST_IDLE);
  assign byte_done = bit_fall && rx_phase && (bitcnt == BIT_LAST);
  assign ack_rise  = scl_rise && (bitcnt == BIT_ACK);
  assign addr_hit  = (rx_sr[DATA_W-1:1] == dev_addr(addr_strap));
  assign addr_done = byte_done && (st == ST_ADDR);
  assign wr_fire   = byte_done && (st == ST_WDATA);
  assign rd_req    = ack_rise && (((st == ST_ADDR) && ack_drv && rw_q) ||
                                  ((st == ST_RDATA) && !sda_f));
  assign mst_nack  = ack_rise && (st == ST_RDATA) && sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      got_rise <= 1'b0;
      rx_sr    <= '0;
      tx_sr    <= '1;
      ack_drv  <= 1'b0;
      rw_q     <= 1'b0;
      inc_q    <= 1'b0;
      ptr_q    <= '0;
      rd_cap   <= 1'b0;
    end else begin
      rd_cap <= rd_req;
      if (start_ev) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        got_rise <= 1'b0;
        ack_drv  <= 1'b0;
      end else if (stop_ev) begin
        st       <= ST_IDLE;
        bitcnt   <= '0;
        got_rise <= 1'b0;
        ack_drv  <= 1'b0;
      end else begin
        if (scl_rise) begin
          got_rise <= 1'b1;
          if (rx_phase && bitcnt < BIT_ACK) rx_sr <= {rx_sr[DATA_W-2:0], sda_f};
          if (mst_nack) st <= ST_IDLE;
        end
        if (bit_fall) begin
          got_rise <= 1'b0;
          bitcnt   <= (bitcnt == BIT_ACK) ? '0 : bitcnt + 1'b1;
          if (st == ST_RDATA && bitcnt < BIT_LAST) tx_sr <= {tx_sr[DATA_W-2:0], 1'b1};
          if (byte_done) begin
            case (st)
              ST_ADDR: begin
                if (addr_hit) begin
                  ack_drv <= 1'b1;
                  rw_q    <= rx_sr[0];
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_SUB: begin
                ack_drv <= 1'b1;
                ptr_q   <= rx_sr[REG_AW-1:0];
                inc_q   <= rx_sr[DATA_W-1];
              end
              default: ack_drv <= 1'b1;
            endcase
          end
          if (bitcnt == BIT_ACK) begin
            ack_drv <= 1'b0;
            case (st)
              ST_ADDR: st <= rw_q ? ST_RDATA : ST_SUB;
              ST_SUB:  st <= ST_WDATA;
              default: st <= st;
            endcase
          end
        end
        if (wr_fire) ptr_q <= ptr_next(ptr_q, inc_q);
        if (rd_cap) begin
          tx_sr <= reg_rdata;
          ptr_q <= ptr_next(ptr_q, inc_q);
        end
      end
    end
  end

  assign sda_oe    = ack_drv || ((st == ST_RDATA) && (bitcnt < BIT_ACK) && !tx_sr[DATA_W-1]);
  assign reg_wr    = wr_fire;
  assign reg_rd    = rd_req;
  assign reg_addr  = ptr_q;
  assign reg_wdata = rx_sr;
endmodule

// File: rtl/i2c_rp_chk.sv
module i2c_rp_chk
  import i2c_rp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic              sda_oe,
  input logic              addr_done,
  input logic              addr_hit,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              mst_nack,
  input logic              inc_q,
  input logic              ack_drv,
  input logic              scl_f
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R6
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd); // R8
  AST_MISS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> !sda_oe); // R3
  AST_ACK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drv && scl_f && !start_ev && !stop_ev) |=> ack_drv); // R4
  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    mst_nack |=> !sda_oe); // R9
  AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R10
  AST_PTR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !inc_q) |=> (reg_addr == $past(reg_addr))); // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && inc_q) |=> (reg_addr == REG_AW'($past(reg_addr) + 1'b1))); // R7
endmodule

bind i2c_regport_slave i2c_rp_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .sda_oe   (sda_oe),
  .addr_done(addr_done),
  .addr_hit (addr_hit),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .mst_nack (mst_nack),
  .inc_q    (inc_q),
  .ack_drv  (ack_drv),
  .scl_f    (scl_f)
);

// File: tb/i2c_regport_slave_tb_top.sv
module i2c_regport_slave_tb_top;
  localparam int Q = 10;  // quarter bit time in clock cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic sda_oe, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata = 8'h00;
  wire sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_regport_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_strap(strap), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] regs [128];
  logic [7:0] exp_mem [128];
  logic [6:0] wl_a [16];
  logic [7:0] wl_d [16];
  logic [7:0] wbuf [4];

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [6:0] exp_addr(input logic [6:0] sub, input logic inc, input int k);
    return 7'((int'(sub) + (inc ? k : 0)) % 128);
  endfunction

  function automatic logic [7:0] addr_byte(input logic lsb, input logic rd);
    return {6'b110100, lsb, rd};
  endfunction

  // Register file behind the port.
  always @(posedge clk) begin
    if (reg_wr) begin
      regs[reg_addr] <= reg_wdata;
      wl_a[wr_cnt[3:0]] <= reg_addr;
      wl_d[wr_cnt[3:0]] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd) begin
      reg_rdata <= regs[reg_addr];
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input logic b, output logic s, input bit glitch);
    m_sda = b; wq(); m_scl = 1'b1; wq();
    s = sda_line;
    if (glitch) begin
      m_sda = ~b; @(posedge clk); #1; m_sda = b;
    end
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked, input int gl_bit);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(d[i], s, i == gl_bit);
    put_bit(1'b1, s, 1'b0);
    acked = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s, 1'b0);
      d[i] = s;
    end
    put_bit(m_ack ? 1'b0 : 1'b1, s, 1'b0);
  endtask

  task automatic do_write(input logic lsb, input logic [6:0] sub, input logic inc,
                          input int n, input int gl_byte);
    bit ak;
    int base = wr_cnt;
    bus_start();
    send_byte(addr_byte(lsb, 1'b0), ak, -1);
    chk(ak, "R3 address ack on write", ak, 1);
    send_byte({inc, sub}, ak, -1);
    chk(ak, "R5 sub-address ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ak, (k == gl_byte) ? 4 : -1);
      chk(ak, "R4 data byte ack", ak, 1);
      exp_mem[exp_addr(sub, inc, k)] = wbuf[k];
    end
    bus_stop();
    chk(wr_cnt == base + n, "R6 write strobe count", wr_cnt - base, n);
    for (int k = 0; k < n; k++) begin
      chk(wl_a[4'(base + k)] == exp_addr(sub, inc, k), "R7 write address",
          wl_a[4'(base + k)], exp_addr(sub, inc, k));
      chk(wl_d[4'(base + k)] == wbuf[k], "R6 write data", wl_d[4'(base + k)], wbuf[k]);
    end
  endtask

  task automatic do_read(input logic lsb, input logic [6:0] sub, input logic inc, input int n);
    bit ak;
    logic [7:0] d;
    int base = rd_cnt;
    bus_start();
    send_byte(addr_byte(lsb, 1'b0), ak, -1);
    chk(ak, "R3 address ack before read", ak, 1);
    send_byte({inc, sub}, ak, -1);
    chk(ak, "R5 sub-address ack before read", ak, 1);
    bus_start();
    send_byte(addr_byte(lsb, 1'b1), ak, -1);
    chk(ak, "R2 repeated START then read address ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(d == exp_mem[exp_addr(sub, inc, k)], "R8 R7 read data", d,
          exp_mem[exp_addr(sub, inc, k)]);
    end
    repeat (3 * Q) @(posedge clk);
    #1;
    chk(sda_oe == 1'b0, "R9 SDA released after NACK", sda_oe, 0);
    chk(rd_cnt == base + n, "R9 read request count", rd_cnt - base, n);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ak;
    logic s;
    int base;
    int unsigned seed = $urandom(32'h1234);
    for (int i = 0; i < 128; i++) begin
      regs[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
    repeat (4) @(posedge clk);
    #1;
    // R11: outputs quiet during and after reset
    chk(sda_oe == 0 && reg_wr == 0 && reg_rd == 0, "R11 outputs in reset",
        {sda_oe, reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    chk(sda_oe == 0 && reg_wr == 0 && reg_rd == 0, "R11 outputs after reset",
        {sda_oe, reg_wr, reg_rd}, 0);

    // R7: fixed pointer burst, last byte wins
    strap = 1'b0;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(1'b0, 7'h10, 1'b0, 3, -1);
    do_read(1'b0, 7'h10, 1'b0, 2);

    // R3: address with the other strap value is ignored
    base = wr_cnt;
    bus_start();
    send_byte(addr_byte(1'b1, 1'b0), ak, -1);
    chk(!ak, "R3 mismatched address not acked", ak, 0);
    send_byte(8'h05, ak, -1);
    chk(!ak, "R3 byte after mismatch not acked", ak, 0);
    send_byte(8'h00, ak, -1);
    chk(!ak && sda_oe == 0, "R3 SDA stays released", ak, 0);
    bus_stop();
    chk(wr_cnt == base, "R3 no write after mismatch", wr_cnt - base, 0);

    // R7: auto-increment wraps at the top of the space, strap high
    strap = 1'b1;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    do_write(1'b1, 7'h7E, 1'b1, 3, -1);
    do_read(1'b1, 7'h7F, 1'b1, 2);

    // R1: one-cycle SDA spike while SCL high inside a data byte
    wbuf[0] = 8'h00; wbuf[1] = 8'h5A;
    do_write(1'b1, 7'h20, 1'b1, 2, 0);

    // R10: bytes after STOP without START are ignored
    base = wr_cnt;
    m_scl = 1'b0; wq();
    send_byte(addr_byte(1'b1, 1'b0), ak, -1);
    chk(!ak, "R10 address after STOP without START not acked", ak, 0);
    send_byte(8'h30, ak, -1);
    send_byte(8'hEE, ak, -1);
    chk(!ak, "R10 data after STOP not acked", ak, 0);
    bus_stop();
    chk(wr_cnt == base, "R10 no write after STOP", wr_cnt - base, 0);

    // R2: repeated START inside a write starts a new address phase
    base = wr_cnt;
    bus_start();
    send_byte(addr_byte(1'b1, 1'b0), ak, -1);
    send_byte(8'h40, ak, -1);
    send_byte(8'h77, ak, -1);
    bus_start();
    send_byte(addr_byte(1'b1, 1'b0), ak, -1);
    chk(ak, "R2 repeated START address ack", ak, 1);
    send_byte(8'h45, ak, -1);
    send_byte(8'h88, ak, -1);
    bus_stop();
    exp_mem[7'h40] = 8'h77;
    exp_mem[7'h45] = 8'h88;
    chk(wr_cnt == base + 2, "R2 writes around repeated START", wr_cnt - base, 2);
    chk(wl_a[4'(base + 1)] == 7'h45 && wl_d[4'(base + 1)] == 8'h88,
        "R2 second segment write", {wl_a[4'(base + 1)], wl_d[4'(base + 1)]}, {7'h45, 8'h88});

    // Random bursts
    for (int it = 0; it < 14; it++) begin
      logic lsb = 1'($urandom);
      logic [6:0] sub = 7'($urandom);
      logic inc = 1'($urandom);
      int n = 1 + int'($urandom % 4);
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      strap = lsb;
      do_write(lsb, sub, inc, n, -1);
      do_read(lsb, sub, inc, n);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule